// File: doc/BRIEF.md
# Stream-to-Memory Receive FIFO with Level Flags

This block is the receive half of a DMA engine. Words arrive on a valid/ready input stream and are stored in a 128-entry FIFO. Once a transfer is started with a base word address and a word count, the block drains that many words from the FIFO to a simple memory write port. Consecutive words go to consecutive word addresses. After the last write is accepted, the block raises a one-cycle done pulse and becomes idle again.

The FIFO occupancy is compared against two programmable thresholds. The first drives a level-hit output. An upstream source that loops data back into this block can use that output to throttle itself, so this threshold only accepts a narrow legal range. The second threshold drives a general watermark flag.

Two independent pause inputs are provided. One freezes the input side of the FIFO and the other freezes the memory side. A byte-swap option reverses the byte order of every word written to memory.

Top module: `s2m_rx_fifo`

## Requirements
- R1: A stream word is accepted on a clock edge where `s_valid` and `s_ready` are both high. `s_ready` is low whenever `level` equals DEPTH (128), and `level` reports the number of words stored in the FIFO.
- R2: `level_hit` is high exactly when `level` is at least the level-hit code plus one. The flag changes on the same clock edge as `level` and as any change of the code.
- R3: A level-hit code below 0x10 acts as 0x10, which means 17 entries. A code above 0x7A acts as 0x7A, which means 123 entries.
- R4: `wm_flag` is high exactly when `level` is at least the watermark code. Codes run from 0 to 128 entries, and any code above 0x80 acts as 128.
- R5: While `pause_in` is high, `s_ready` is low and no word enters the FIFO.
- R6: A `start` pulse while idle captures `base_addr` and `word_count`. Words are then written in arrival order to `base_addr`, `base_addr+1`, and so on, one per handshake where `m_wr_valid` and `m_wr_ready` are both high. A write that is presented and not yet accepted keeps its address and data unchanged.
- R7: While `pause_out` is high, no new write is presented. Clearing it resumes the transfer where it stopped.
- R8: When `swap_bytes` is 1 at `start`, each written word has its four bytes in reverse order: bits [7:0] move to [31:24], and so on. When it is 0, the word is written unchanged.
- R9: `done` pulses for one cycle, with `busy` low, on the edge that accepts the last write. A `word_count` of 0 pulses `done` on the edge after `start`. A `start` while busy is ignored.
- R10: After reset, `level` is 0, `s_ready` is 1, and `busy`, `done`, `m_wr_valid`, `level_hit` and `wm_flag` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Start a transfer (one-cycle pulse) |
| base_addr | input | AW (32) | First word address |
| word_count | input | CW (16) | Number of words to write |
| swap_bytes | input | 1 | Reverse byte order for the transfer |
| hit_code | input | LW (8) | Level-hit threshold code |
| wm_code | input | LW (8) | Watermark threshold |
| pause_in | input | 1 | Freeze the stream side |
| pause_out | input | 1 | Stop presenting new writes |
| s_valid | input | 1 | Stream word valid |
| s_data | input | 32 | Stream word |
| s_ready | output | 1 | Stream ready |
| m_wr_valid | output | 1 | Memory write presented |
| m_wr_addr | output | AW (32) | Memory word address |
| m_wr_data | output | 32 | Memory write data |
| m_wr_ready | input | 1 | Memory accepts write |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | Transfer complete pulse |
| level | output | LW (8) | FIFO occupancy |
| level_hit | output | 1 | Occupancy reached level-hit threshold |
| wm_flag | output | 1 | Occupancy reached watermark |

## Verification
Timing of each result:
- `level`, `level_hit` and `wm_flag` all settle on the edge that moves a word into or out of the FIFO. A changed threshold code takes effect on the next edge.
- `s_ready` follows the pause input and the occupancy within the same cycle.
- A write is presented one edge after it is issued from the FIFO.
- `done` appears on the edge that accepts the final write.

How the checks keep to that timing:
- Inputs are driven on the falling clock edge, and flags and levels are read at the next falling edge. One rising edge therefore lies between stimulus and check.
- Write handshakes and done pulses are collected at the rising edge, where the design's registered outputs still show their pre-edge values. Addresses, data and counts are then compared against values that the bench computes itself.

// File: rtl/s2m_pkg.sv
package s2m_pkg;
  localparam int WORD_W = 32;

  // Reverse the byte lanes of one word.
  function automatic logic [WORD_W-1:0] byte_swap(input logic [WORD_W-1:0] w);
    logic [WORD_W-1:0] r;
    for (int b = 0; b < WORD_W / 8; b++) begin
      r[8*b +: 8] = w[WORD_W-8-8*b +: 8];
    end
    return r;
  endfunction
endpackage

// File: rtl/s2m_fifo.sv
module s2m_fifo #(
  parameter int DEPTH = 128,
  parameter int DW    = 32,
  localparam int PW   = $clog2(DEPTH),
  localparam int LW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          push,
  input  logic [DW-1:0] push_data,
  input  logic          pop,
  output logic [DW-1:0] pop_data,
  output logic [LW-1:0] count,
  output logic [LW-1:0] count_nxt,
  output logic          full,
  output logic          empty
);
  logic [DW-1:0] mem [DEPTH];
  logic [PW-1:0] wp, rp;
  logic [DW-1:0] rd_q;

  // Storage without reset so that it maps onto block RAM.
  always_ff @(posedge clk) begin
    if (push) mem[wp] <= push_data;
    if (pop)  rd_q    <= mem[rp];
  end

  always_comb begin
    case ({push, pop})
      2'b10:   count_nxt = count + LW'(1);
      2'b01:   count_nxt = count - LW'(1);
      default: count_nxt = count;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wp    <= '0;
      rp    <= '0;
      count <= '0;
    end else begin
      if (push) wp <= (wp == PW'(DEPTH - 1)) ? '0 : wp + PW'(1);
      if (pop)  rp <= (rp == PW'(DEPTH - 1)) ? '0 : rp + PW'(1);
      count <= count_nxt;
    end
  end

  assign full     = (count == LW'(DEPTH));
  assign empty    = (count == '0);
  assign pop_data = rd_q;

  a_r1_no_overflow: assert property (@(posedge clk) disable iff (rst)
    push |-> (count != LW'(DEPTH)));
  a_r1_no_underflow: assert property (@(posedge clk) disable iff (rst)
    pop |-> (count != '0));
endmodule

// File: rtl/s2m_levels.sv
module s2m_levels #(
  parameter int DEPTH  = 128,
  parameter int HIT_LO = 16,
  parameter int HIT_HI = 122,
  localparam int LW    = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [LW-1:0] occ_nxt,
  input  logic [LW-1:0] hit_code,
  input  logic [LW-1:0] wm_code,
  output logic          level_hit,
  output logic          wm_flag
);
  logic [LW-1:0] hit_thr, wm_thr;

  // Clamp the codes into their legal ranges.
  always_comb begin
    if (hit_code < LW'(HIT_LO))      hit_thr = LW'(HIT_LO + 1);
    else if (hit_code > LW'(HIT_HI)) hit_thr = LW'(HIT_HI + 1);
    else                             hit_thr = hit_code + LW'(1);
    wm_thr = (wm_code > LW'(DEPTH)) ? LW'(DEPTH) : wm_code;
  end

  // Compare against the next occupancy so the flags line up with the level.
  always_ff @(posedge clk) begin
    if (rst) begin
      level_hit <= 1'b0;
      wm_flag   <= 1'b0;
    end else begin
      level_hit <= (occ_nxt >= hit_thr);
      wm_flag   <= (occ_nxt >= wm_thr);
    end
  end
endmodule

// File: rtl/s2m_writer.sv
module s2m_writer #(
  parameter int AW = 32,
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic [AW-1:0] base_addr,
  input  logic [CW-1:0] word_count,
  input  logic          pause_out,
  input  logic          fifo_empty,
  output logic          pop,
  output logic          m_valid,
  output logic [AW-1:0] m_addr,
  input  logic          m_ready,
  output logic          busy,
  output logic          done
);
  logic [CW-1:0] issue_left, beat_left;
  logic [AW-1:0] addr_q;

  assign pop = busy && !pause_out && !fifo_empty && (issue_left != '0)
               && (!m_valid || m_ready);

  always_ff @(posedge clk) begin
    if (rst) begin
      busy       <= 1'b0;
      done       <= 1'b0;
      issue_left <= '0;
      beat_left  <= '0;
      addr_q     <= '0;
      m_valid    <= 1'b0;
      m_addr     <= '0;
    end else begin
      done <= 1'b0;
      if (!busy && start) begin
        if (word_count == '0) begin
          done <= 1'b1;
        end else begin
          busy       <= 1'b1;
          issue_left <= word_count;
          beat_left  <= word_count;
          addr_q     <= base_addr;
        end
      end
      if (pop) begin
        m_valid    <= 1'b1;
        m_addr     <= addr_q;
        addr_q     <= addr_q + AW'(1);
        issue_left <= issue_left - CW'(1);
      end else if (m_ready) begin
        m_valid <= 1'b0;
      end
      if (m_valid && m_ready) begin
        beat_left <= beat_left - CW'(1);
        if (beat_left == CW'(1)) begin
          busy <= 1'b0;
          done <= 1'b1;
        end
      end
    end
  end

  a_r6_hold_write: assert property (@(posedge clk) disable iff (rst)
    (m_valid && !m_ready) |=> (m_valid && $stable(m_addr)));
  a_r7_pause_blocks: assert property (@(posedge clk) disable iff (rst)
    (pause_out && !m_valid) |=> !m_valid);
  a_r9_done_idle: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);
endmodule

// File: rtl/s2m_rx_fifo.sv
module s2m_rx_fifo
  import s2m_pkg::*;
#(
  parameter int DEPTH  = 128,
  parameter int AW     = 32,
  parameter int CW     = 16,
  parameter int HIT_LO = 16,
  parameter int HIT_HI = 122,
  localparam int LW    = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [AW-1:0]     base_addr,
  input  logic [CW-1:0]     word_count,
  input  logic              swap_bytes,
  input  logic [LW-1:0]     hit_code,
  input  logic [LW-1:0]     wm_code,
  input  logic              pause_in,
  input  logic              pause_out,
  input  logic              s_valid,
  input  logic [WORD_W-1:0] s_data,
  output logic              s_ready,
  output logic              m_wr_valid,
  output logic [AW-1:0]     m_wr_addr,
  output logic [WORD_W-1:0] m_wr_data,
  input  logic              m_wr_ready,
  output logic              busy,
  output logic              done,
  output logic [LW-1:0]     level,
  output logic              level_hit,
  output logic              wm_flag
);
  logic              push, pop, full, empty;
  logic [LW-1:0]     occ_nxt;
  logic [WORD_W-1:0] rd_word;
  logic              swap_q;

  assign s_ready = !full && !pause_in;
  assign push    = s_valid && s_ready;

  s2m_fifo #(.DEPTH(DEPTH), .DW(WORD_W)) u_fifo (
    .clk(clk), .rst(rst), .push(push), .push_data(s_data),
    .pop(pop), .pop_data(rd_word), .count(level), .count_nxt(occ_nxt),
    .full(full), .empty(empty)
  );

  s2m_levels #(.DEPTH(DEPTH), .HIT_LO(HIT_LO), .HIT_HI(HIT_HI)) u_levels (
    .clk(clk), .rst(rst), .occ_nxt(occ_nxt), .hit_code(hit_code),
    .wm_code(wm_code), .level_hit(level_hit), .wm_flag(wm_flag)
  );

  s2m_writer #(.AW(AW), .CW(CW)) u_writer (
    .clk(clk), .rst(rst), .start(start), .base_addr(base_addr),
    .word_count(word_count), .pause_out(pause_out), .fifo_empty(empty),
    .pop(pop), .m_valid(m_wr_valid), .m_addr(m_wr_addr),
    .m_ready(m_wr_ready), .busy(busy), .done(done)
  );

  // Byte order is fixed for the whole transfer.
  always_ff @(posedge clk) begin
    if (rst)                swap_q <= 1'b0;
    else if (!busy && start) swap_q <= swap_bytes;
  end

  assign m_wr_data = swap_q ? byte_swap(rd_word) : rd_word;

  a_r2_hit_floor: assert property (@(posedge clk) disable iff (rst)
    level_hit |-> (level >= LW'(HIT_LO + 1)));
  a_r6_hold_data: assert property (@(posedge clk) disable iff (rst)
    (m_wr_valid && !m_wr_ready) |=> $stable(m_wr_data));
  a_r5_pause_in: assert property (@(posedge clk) disable iff (rst)
    pause_in |=> (level <= $past(level)));
endmodule

// File: tb/s2m_rx_fifo_test.sv
module s2m_rx_fifo_test;
  localparam int LW = 8;

  logic        clk = 1'b0, rst = 1'b1;
  logic        start = 1'b0, swap_bytes = 1'b0;
  logic [31:0] base_addr = '0;
  logic [15:0] word_count = '0;
  logic [7:0]  hit_code = 8'h10, wm_code = 8'd5;
  logic        pause_in = 1'b0, pause_out = 1'b0;
  logic        s_valid = 1'b0;
  logic [31:0] s_data = '0;
  logic        m_wr_ready = 1'b1;
  logic        s_ready, m_wr_valid, busy, done, level_hit, wm_flag;
  logic [31:0] m_wr_addr, m_wr_data;
  logic [7:0]  level;

  int checks = 0, errors = 0;
  int wr_n = 0, done_cnt = 0, pushed = 0;
  logic [31:0] cap_addr [256];
  logic [31:0] cap_data [256];

  s2m_rx_fifo uut (
    .clk(clk), .rst(rst), .start(start), .base_addr(base_addr),
    .word_count(word_count), .swap_bytes(swap_bytes), .hit_code(hit_code),
    .wm_code(wm_code), .pause_in(pause_in), .pause_out(pause_out),
    .s_valid(s_valid), .s_data(s_data), .s_ready(s_ready),
    .m_wr_valid(m_wr_valid), .m_wr_addr(m_wr_addr), .m_wr_data(m_wr_data),
    .m_wr_ready(m_wr_ready), .busy(busy), .done(done), .level(level),
    .level_hit(level_hit), .wm_flag(wm_flag)
  );

  always #5 clk = ~clk;

  always @(posedge clk) begin
    if (!rst) begin
      if (m_wr_valid && m_wr_ready) begin
        cap_addr[wr_n[7:0]] = m_wr_addr;
        cap_data[wr_n[7:0]] = m_wr_data;
        wr_n++;
      end
      if (done) done_cnt++;
    end
  end

  function automatic logic [31:0] pat(input int i);
    return {8'hA5, 8'(i), 8'(~i), 8'h3C};
  endfunction

  function automatic logic [31:0] rev(input logic [31:0] w);
    return {w[7:0], w[15:8], w[23:16], w[31:24]};
  endfunction

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic push_n(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      s_valid = 1'b1;
      s_data  = pat(pushed);
      pushed++;
    end
    @(negedge clk);
    s_valid = 1'b0;
  endtask

  task automatic kick(input logic [31:0] base, input logic [15:0] cnt, input logic sw);
    @(negedge clk);
    start = 1'b1; base_addr = base; word_count = cnt; swap_bytes = sw;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic wait_done(input int target);
    for (int i = 0; i < 3000 && done_cnt < target; i++) @(negedge clk);
  endtask

  task automatic t_reset;
    chk("R10 level", level, 0);
    chk("R10 s_ready", s_ready, 1);
    chk("R10 busy/done/valid", {busy, done, m_wr_valid}, 0);
    chk("R10 flags", {level_hit, wm_flag}, 0);
  endtask

  task automatic t_levels;
    push_n(4);
    chk("R1 level after 4", level, 4);
    chk("R4 wm below", wm_flag, 0);
    push_n(1);
    chk("R4 wm at threshold", wm_flag, 1);
    push_n(11);
    chk("R2 hit at 16", level_hit, 0);
    hit_code = 8'h02;
    @(negedge clk);
    chk("R3 low clamp 0x02 at 16", level_hit, 0);
    hit_code = 8'h0F;
    @(negedge clk);
    chk("R3 low clamp 0x0F at 16", level_hit, 0);
    hit_code = 8'h10;
    push_n(1);
    chk("R2 hit at 17", level_hit, 1);
    hit_code = 8'h11;
    @(negedge clk);
    chk("R2 code 0x11 at 17", level_hit, 0);
    hit_code = 8'h10;
    @(negedge clk);
    chk("R2 code 0x10 restored", level_hit, 1);
  endtask

  task automatic t_pause_in;
    pause_in = 1'b1;
    s_valid  = 1'b1;
    s_data   = 32'hDEAD_BEEF;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      chk("R5 s_ready low", s_ready, 0);
    end
    s_valid = 1'b0;
    chk("R5 level unchanged", level, 17);
    pause_in = 1'b0;
    #1;
    chk("R5 ready back", s_ready, 1);
  endtask

  task automatic t_full;
    push_n(106);
    chk("R1 level 123", level, 123);
    hit_code = 8'h7F;
    @(negedge clk);
    chk("R3 high clamp 0x7F at 123", level_hit, 1);
    push_n(5);
    chk("R1 level full", level, 128);
    chk("R1 ready low when full", s_ready, 0);
    s_valid = 1'b1;
    s_data  = 32'h0BAD_0BAD;
    repeat (2) @(negedge clk);
    s_valid = 1'b0;
    chk("R1 no overflow", level, 128);
    wm_code = 8'hC0;
    @(negedge clk);
    chk("R4 wm clamp 0xC0 at 128", wm_flag, 1);
    wm_code = 8'd5;
    hit_code = 8'h10;
  endtask

  task automatic t_drain;
    int bad_a = 0, bad_d = 0;
    kick(32'h100, 16'd128, 1'b0);
    repeat (10) @(negedge clk);
    kick(32'h0, 16'd5, 1'b1);
    wait_done(1);
    repeat (6) @(negedge clk);
    chk("R6 write count", wr_n, 128);
    chk("R9 single done", done_cnt, 1);
    for (int i = 0; i < 128; i++) begin
      if (cap_addr[i] !== 32'h100 + i) bad_a++;
      if (cap_data[i] !== pat(i)) bad_d++;
    end
    chk("R6 addresses in order", bad_a, 0);
    chk("R6 data in order", bad_d, 0);
    chk("R9 idle after done", busy, 0);
    chk("R1 empty after drain", level, 0);
    chk("R4 wm off when empty", wm_flag, 0);
  endtask

  task automatic t_pause_swap;
    push_n(4);
    pause_out = 1'b1;
    kick(32'h40, 16'd4, 1'b1);
    repeat (8) @(negedge clk);
    chk("R7 no writes while paused", wr_n, 128);
    chk("R7 busy while paused", busy, 1);
    chk("R7 fifo held", level, 4);
    m_wr_ready = 1'b0;
    pause_out  = 1'b0;
    repeat (3) @(negedge clk);
    chk("R6 write held", {m_wr_valid, m_wr_addr}, {1'b1, 32'h40});
    chk("R8 held data swapped", m_wr_data, rev(pat(128)));
    chk("R6 nothing accepted", wr_n, 128);
    m_wr_ready = 1'b1;
    wait_done(2);
    @(negedge clk);
    chk("R7 resumed writes", wr_n, 132);
    for (int i = 0; i < 4; i++) begin
      chk("R6 addr after pause", cap_addr[128 + i], 32'h40 + i);
      chk("R8 swapped data", cap_data[128 + i], rev(pat(128 + i)));
    end
  endtask

  task automatic t_zero;
    kick(32'h0, 16'd0, 1'b0);
    chk("R9 zero-count done pulse", {done, busy}, 2'b10);
    @(negedge clk);
    chk("R9 done one cycle", done, 0);
    chk("R9 no writes", wr_n, 132);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_levels();
    t_pause_in();
    t_full();
    t_drain();
    t_pause_swap();
    t_zero();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog R9: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule